// File: doc/BRIEF.md
# Encoded-Function 8-bit ALU

This block is an arithmetic and logic unit controlled by a sequencer. It holds two operand registers, A and B, and a 4-bit function register. Each of these is loaded by its own strobe from a shared data input. A read strobe evaluates the selected function on the stored operands and registers the result. The carry flag is updated in the same step.

A typical use takes four cycles, each with one command: load A, load B, set the function, then read. The function code chooses the operation. For arithmetic codes it also chooses the carry-in, which is a forced 0, a forced 1 or the carry flag left by an earlier arithmetic read. The registered result drives a sign output that a condition multiplexer outside the block can test. A combinational equality output shows whether the two stored operands match.

Top module: `ualu_engine`

## Requirements
- R1: While `rst_n` is low and after its release, until the first load or read, `result_o` is 0, `carry_o` is 0, `sign_o` is 0, and A, B and the function register are 0.
- R2: On a clock edge, `a_ld_i` stores `din_i` into A, `b_ld_i` stores `din_i` into B and `fn_ld_i` stores `fn_i` into the function register. A read in the same cycle uses the values held before that edge. The result of a read appears on `result_o` one cycle after `rd_i`.
- R3: Code 0 gives A+B with carry-in 0. Code 1 gives A+B+carry flag. Both are modulo 256.
- R4: Code 2 gives A+~B+1, which is A−B. Code 3 gives A+~B+carry flag. A carry-out of 1 means no borrow.
- R5: Code 4 gives A+A with carry-in 0. Code 5 gives A+A+carry flag.
- R6: A read of codes 0–5 loads bit 8 of the 9-bit sum into the carry flag (`carry_o`). No other cycle changes the flag.
- R7: Codes 8 to 13 give A, B, A AND B, A OR B, NOT A and A XOR B, in that order of code. They leave the carry flag unchanged.
- R8: Code 14 gives the bitwise match mask NOT(A XOR B), which is 8'hFF exactly when A equals B. `eq_o` is high whenever the stored A and B are equal.
- R9: Codes 6, 7 and 15 give 0 and leave the carry flag unchanged.
- R10: `sign_o` equals bit 7 of `result_o`, so the sign test of code 8 reports whether A is negative.
- R11: `result_o` holds its value in every cycle without `rd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din_i | input | 8 | Operand data input |
| a_ld_i | input | 1 | Store din_i into operand A |
| b_ld_i | input | 1 | Store din_i into operand B |
| fn_i | input | 4 | Function code |
| fn_ld_i | input | 1 | Store fn_i into the function register |
| rd_i | input | 1 | Evaluate and register the result |
| result_o | output | 8 | Registered result |
| carry_o | output | 1 | Carry flag |
| sign_o | output | 1 | Sign of the registered result |
| eq_o | output | 1 | Stored A equals stored B |

## Verification
The assertions check on every cycle that the carry flag and the result move only on a read. They also check that unused and logic codes keep the flag, that the pass codes return the operand read, and that a match gives all ones. The arithmetic values depend on a carry chained across reads: the bench shows ADC, SBB and ROL consuming a flag left by an earlier read. Together with random operand and function sequences, these scenarios cover the sums, borrows and reset state.

// File: rtl/ualu_pkg.sv
package ualu_pkg;

  localparam int FN_W = 4;

  typedef enum logic [FN_W-1:0] {
    FN_ADD   = 4'd0,
    FN_ADC   = 4'd1,
    FN_SUB   = 4'd2,
    FN_SBB   = 4'd3,
    FN_ASL   = 4'd4,
    FN_ROL   = 4'd5,
    FN_RSV6  = 4'd6,
    FN_RSV7  = 4'd7,
    FN_PASSA = 4'd8,
    FN_PASSB = 4'd9,
    FN_AND   = 4'd10,
    FN_OR    = 4'd11,
    FN_NOTA  = 4'd12,
    FN_XOR   = 4'd13,
    FN_MATCH = 4'd14,
    FN_RSV15 = 4'd15
  } fn_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_e;

  typedef enum logic [2:0] {
    LOP_PASSA = 3'd0,
    LOP_PASSB = 3'd1,
    LOP_AND   = 3'd2,
    LOP_OR    = 3'd3,
    LOP_NOTA  = 3'd4,
    LOP_XOR   = 3'd5,
    LOP_XNOR  = 3'd6,
    LOP_ZERO  = 3'd7
  } lop_e;

  typedef struct packed {
    logic arith;     // arithmetic mode, taken from code bit 3
    logic valid;     // code is defined
    logic invert_b;  // subtract path
    logic double_a;  // shift path: second operand is A
    cin_e cin_sel;
    lop_e lop;
  } dec_t;

endpackage

// File: rtl/ualu_decode.sv
module ualu_decode
  import ualu_pkg::*;
(
  input  logic [FN_W-1:0] fn_code,
  output dec_t            dec
);

  fn_e fn;
  assign fn = fn_e'(fn_code);

  always_comb begin
    dec          = '0;
    dec.arith    = ~fn_code[FN_W-1];
    dec.valid    = 1'b1;
    dec.cin_sel  = CIN_ZERO;
    dec.lop      = LOP_ZERO;
    unique case (fn)
      FN_ADD:   dec.cin_sel = CIN_ZERO;
      FN_ADC:   dec.cin_sel = CIN_FLAG;
      FN_SUB: begin
        dec.invert_b = 1'b1;
        dec.cin_sel  = CIN_ONE;
      end
      FN_SBB: begin
        dec.invert_b = 1'b1;
        dec.cin_sel  = CIN_FLAG;
      end
      FN_ASL: begin
        dec.double_a = 1'b1;
        dec.cin_sel  = CIN_ZERO;
      end
      FN_ROL: begin
        dec.double_a = 1'b1;
        dec.cin_sel  = CIN_FLAG;
      end
      FN_PASSA: dec.lop = LOP_PASSA;
      FN_PASSB: dec.lop = LOP_PASSB;
      FN_AND:   dec.lop = LOP_AND;
      FN_OR:    dec.lop = LOP_OR;
      FN_NOTA:  dec.lop = LOP_NOTA;
      FN_XOR:   dec.lop = LOP_XOR;
      FN_MATCH: dec.lop = LOP_XNOR;
      default:  dec.valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/ualu_core.sv
module ualu_core
  import ualu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  dec_t         dec,
  input  logic         flag,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         cin_bit,
  output logic         match_all
);

  localparam int SUM_W = W + 1;

  function automatic logic [SUM_W-1:0] add_chain(
    input logic [W-1:0] x,
    input logic [W-1:0] y,
    input logic         c
  );
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  function automatic logic [W-1:0] logic_op(
    input lop_e         op,
    input logic [W-1:0] x,
    input logic [W-1:0] y
  );
    logic [W-1:0] r;
    case (op)
      LOP_PASSA: r = x;
      LOP_PASSB: r = y;
      LOP_AND:   r = x & y;
      LOP_OR:    r = x | y;
      LOP_NOTA:  r = ~x;
      LOP_XOR:   r = x ^ y;
      LOP_XNOR:  r = ~(x ^ y);
      default:   r = '0;
    endcase
    return r;
  endfunction

  logic [W-1:0]     op2;
  logic [SUM_W-1:0] sum;
  logic [W-1:0]     bit_match;

  always_comb begin
    unique case (dec.cin_sel)
      CIN_ONE:  cin_bit = 1'b1;
      CIN_FLAG: cin_bit = flag;
      default:  cin_bit = 1'b0;
    endcase
  end

  assign op2 = dec.double_a ? a : (dec.invert_b ? ~b : b);
  assign sum = add_chain(a, op2, cin_bit);

  always_comb begin
    if (!dec.valid)     res = '0;
    else if (dec.arith) res = sum[W-1:0];
    else                res = logic_op(dec.lop, a, b);
  end

  assign cout = sum[SUM_W-1];

  for (genvar i = 0; i < W; i++) begin : g_match
    assign bit_match[i] = ~(a[i] ^ b[i]);
  end
  assign match_all = &bit_match;

endmodule

// File: rtl/ualu_flag.sv
module ualu_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic cout,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (upd) flag_q <= cout;
  end

endmodule

// File: rtl/ualu_engine.sv
module ualu_engine
  import ualu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    din_i,
  input  logic            a_ld_i,
  input  logic            b_ld_i,
  input  logic [FN_W-1:0] fn_i,
  input  logic            fn_ld_i,
  input  logic            rd_i,
  output logic [W-1:0]    result_o,
  output logic            carry_o,
  output logic            sign_o,
  output logic            eq_o
);

  localparam int MSB = W - 1;

  logic [W-1:0]    a_q;
  logic [W-1:0]    b_q;
  logic [FN_W-1:0] fn_q;
  logic [W-1:0]    res_q;
  dec_t            dec;
  logic [W-1:0]    res_d;
  logic            cout;
  logic            cin_bit;
  logic            match_all;
  logic            carry_upd;
  logic            cin_used;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      fn_q <= '0;
    end else begin
      if (a_ld_i)  a_q  <= din_i;
      if (b_ld_i)  b_q  <= din_i;
      if (fn_ld_i) fn_q <= fn_i;
    end
  end

  ualu_decode u_dec (
    .fn_code (fn_q),
    .dec     (dec)
  );

  ualu_core #(.W(W)) u_core (
    .a         (a_q),
    .b         (b_q),
    .dec       (dec),
    .flag      (carry_o),
    .res       (res_d),
    .cout      (cout),
    .cin_bit   (cin_bit),
    .match_all (match_all)
  );

  assign carry_upd = rd_i & dec.arith & dec.valid;
  assign cin_used  = carry_upd & cin_bit;

  ualu_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (carry_upd),
    .cout   (cout),
    .flag_q (carry_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    res_q <= '0;
    else if (rd_i) res_q <= res_d;
  end

  assign result_o = res_q;
  assign sign_o   = res_q[MSB];
  assign eq_o     = match_all;

endmodule

// File: rtl/ualu_chk.sv
module ualu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rd_i,
  input logic [3:0]   fn_q,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_q,
  input logic         carry_upd,
  input logic [W-1:0] result_o,
  input logic         carry_o
);

  logic unused_code;
  logic logic_code;
  assign unused_code = (fn_q == 4'd6) || (fn_q == 4'd7) || (fn_q == 4'd15);
  assign logic_code  = fn_q[3];

  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(carry_o));

  assert_flag_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    carry_upd |-> (rd_i && !fn_q[3] && !unused_code));

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && unused_code) |=> (result_o == '0) && $stable(carry_o));

  assert_logic_keeps_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && logic_code) |=> $stable(carry_o));

  assert_pass_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && fn_q == 4'd8) |=> result_o == $past(a_q));

  assert_pass_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && fn_q == 4'd9) |=> result_o == $past(b_q));

  assert_match_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && fn_q == 4'd14 && a_q == b_q) |=> &result_o);

  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(result_o));

endmodule

bind ualu_engine ualu_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_i      (rd_i),
  .fn_q      (fn_q),
  .a_q       (a_q),
  .b_q       (b_q),
  .carry_upd (carry_upd),
  .result_o  (result_o),
  .carry_o   (carry_o)
);

// File: tb/tb_ualu_engine.sv
module tb_ualu_engine;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] din_i = '0;
  logic       a_ld_i = 1'b0;
  logic       b_ld_i = 1'b0;
  logic [3:0] fn_i = '0;
  logic       fn_ld_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] result_o;
  logic       carry_o;
  logic       sign_o;
  logic       eq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model of stored state
  logic [7:0] m_a = '0;
  logic [7:0] m_b = '0;
  logic [3:0] m_fn = '0;
  logic       m_cf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ualu_engine dut (
    .clk(clk), .rst_n(rst_n), .din_i(din_i), .a_ld_i(a_ld_i), .b_ld_i(b_ld_i),
    .fn_i(fn_i), .fn_ld_i(fn_ld_i), .rd_i(rd_i), .result_o(result_o),
    .carry_o(carry_o), .sign_o(sign_o), .eq_o(eq_o)
  );

  // expected value, written as signed-free integer arithmetic
  function automatic void model(input logic [3:0] f, input logic [7:0] a,
                                input logic [7:0] b, input logic cf,
                                output logic [7:0] r, output logic nc);
    int s;
    nc = cf;
    r  = 8'h00;
    case (f)
      4'd0: s = int'(a) + int'(b);
      4'd1: s = int'(a) + int'(b) + int'(cf);
      4'd2: s = int'(a) + (255 - int'(b)) + 1;
      4'd3: s = int'(a) + (255 - int'(b)) + int'(cf);
      4'd4: s = 2 * int'(a);
      4'd5: s = 2 * int'(a) + int'(cf);
      default: s = -1;
    endcase
    if (s >= 0) begin
      r  = 8'(s % 256);
      nc = (s >= 256);
    end else begin
      case (f)
        4'd8:  r = a;
        4'd9:  r = b;
        4'd10: r = a & b;
        4'd11: r = a | b;
        4'd12: r = ~a;
        4'd13: r = a ^ b;
        4'd14: for (int i = 0; i < 8; i++) r[i] = (a[i] == b[i]);
        default: r = 8'h00;
      endcase
    end
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd_a(input logic [7:0] v);
    @(negedge clk); din_i = v; a_ld_i = 1'b1;
    @(negedge clk); a_ld_i = 1'b0; m_a = v;
  endtask

  task automatic cmd_b(input logic [7:0] v);
    @(negedge clk); din_i = v; b_ld_i = 1'b1;
    @(negedge clk); b_ld_i = 1'b0; m_b = v;
  endtask

  task automatic cmd_fn(input logic [3:0] f);
    @(negedge clk); fn_i = f; fn_ld_i = 1'b1;
    @(negedge clk); fn_ld_i = 1'b0; m_fn = f;
  endtask

  // read and check result, sign and carry one cycle later
  task automatic cmd_rd(input string req);
    logic [7:0] er;
    logic       ec;
    model(m_fn, m_a, m_b, m_cf, er, ec);
    @(negedge clk); rd_i = 1'b1;
    @(negedge clk); rd_i = 1'b0;
    m_cf = ec;
    check(req, {24'd0, result_o}, {24'd0, er});
    check(req, {31'd0, carry_o}, {31'd0, ec});
    check("R10", {31'd0, sign_o}, {31'd0, er[7]});
  endtask

  task automatic op(input logic [3:0] f, input logic [7:0] a, input logic [7:0] b,
                    input string req);
    cmd_a(a); cmd_b(b); cmd_fn(f); cmd_rd(req);
  endtask

  function automatic string req_of(input logic [3:0] f);
    case (f)
      4'd0, 4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd14:      return "R8";
      4'd6, 4'd7, 4'd15: return "R9";
      default:    return "R7";
    endcase
  endfunction

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {24'd0, result_o}, 32'd0);
    check("R1", {31'd0, carry_o}, 32'd0);
    check("R1", {31'd0, eq_o}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {24'd0, result_o}, 32'd0);
    check("R1", {31'd0, sign_o}, 32'd0);

    // R3 carry generation then ADC consuming it
    op(4'd0, 8'hFF, 8'h01, "R3");
    check("R6", {31'd0, carry_o}, 32'd1);
    op(4'd1, 8'h10, 8'h20, "R3");
    check("R3", {24'd0, result_o}, 32'h31);
    // R9 unused codes keep carry
    op(4'd0, 8'h80, 8'h80, "R3");
    op(4'd6, 8'h12, 8'h34, "R9");
    op(4'd7, 8'h12, 8'h34, "R9");
    op(4'd15, 8'hAA, 8'h55, "R9");
    check("R9", {31'd0, carry_o}, 32'd1);
    // R7 logic keeps carry
    op(4'd11, 8'h0F, 8'hF0, "R7");
    check("R7", {31'd0, carry_o}, 32'd1);
    // R4 subtraction, equal operands no borrow; borrow case; SBB chain
    op(4'd2, 8'h40, 8'h40, "R4");
    check("R4", {24'd0, result_o}, 32'h00);
    op(4'd2, 8'h00, 8'h01, "R4");
    check("R4", {31'd0, carry_o}, 32'd0);
    op(4'd3, 8'h05, 8'h02, "R4");
    check("R4", {24'd0, result_o}, 32'h02);
    // R5 shifts
    op(4'd4, 8'hC1, 8'h00, "R5");
    op(4'd5, 8'h01, 8'h00, "R5");
    check("R5", {24'd0, result_o}, 32'h03);
    // R10 sign test via pass A
    op(4'd8, 8'h80, 8'h00, "R10");
    check("R10", {31'd0, sign_o}, 32'd1);
    // R8 equality
    op(4'd14, 8'h5A, 8'h5A, "R8");
    check("R8", {31'd0, eq_o}, 32'd1);
    op(4'd14, 8'h5A, 8'h5B, "R8");
    check("R8", {31'd0, eq_o}, 32'd0);
    // R2 read in same cycle as load uses old A
    cmd_a(8'h11); cmd_b(8'h22); cmd_fn(4'd8);
    @(negedge clk); din_i = 8'h99; a_ld_i = 1'b1; rd_i = 1'b1;
    @(negedge clk); a_ld_i = 1'b0; rd_i = 1'b0; m_a = 8'h99;
    check("R2", {24'd0, result_o}, 32'h11);
    // R11 result holds without read
    cmd_b(8'h77);
    repeat (3) @(negedge clk);
    check("R11", {24'd0, result_o}, 32'h11);
    // R6 no flag change from loads alone
    check("R6", {31'd0, carry_o}, {31'd0, m_cf});

    // random sequences, fixed seed
    void'($urandom(32'h1F2E3D4C));
    for (int n = 0; n < 400; n++) begin
      logic [3:0] f;
      f = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) != 0) cmd_a(8'($urandom));
      if ($urandom_range(0, 3) != 0) cmd_b(8'($urandom));
      cmd_fn(f);
      cmd_rd(req_of(f));
      check("R8", {31'd0, eq_o}, {31'd0, (m_a == m_b)});
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule